// File: doc/BRIEF.md
# Dual-Mode Pulse Count and Hit Timestamp Digitizer

This block turns a stream of single-cycle events into binary numbers and sends them out over one serial line. A static mode input decides what the block measures. In signal mode it integrates: after a start request it counts the event pulses that arrive from a quantizer during a programmable number of clock cycles. The final count is proportional to the integrated input, and it is stored when the window closes. In time mode it acts as a time-to-digital converter: after a start request it counts reference ticks, and each hit pulse stores the running count as a timestamp. The timestamp resolution is one reference tick.

One 15-bit saturating counter serves both modes. A multiplexer in front of it selects the pulse source. Stored results go into a four-entry shift-register buffer, so several hits in one interval are kept. A parallel-to-serial stage drains the buffer. Each result leaves as a 16-bit frame with a valid strobe and a frame-start marker.

Top module: `pulse_time_digitizer`

## Requirements
- R1: After reset, `ser_valid`, `ser_frame` and `overflow` are low, and no frame is sent until a result has been captured.
- R2: With `mode_time` = 0 only `evt_in` pulses advance the counter and `ref_tick` has no effect. With `mode_time` = 1 only `ref_tick` pulses advance it and `evt_in` has no effect.
- R3: In signal mode, the result of a start request is the number of cycles with `evt_in` high among the `win_len` cycles that follow the start cycle. Each window gives exactly one result. Events after the window has closed are not counted. `win_len` = 0 gives a result of 0.
- R4: In time mode, a hit sampled high while an interval is running stores the number of `ref_tick` pulses sampled from the cycle after the start cycle up to, but not including, the hit cycle.
- R5: `start` clears the counter and its overrange bit, then begins a new window or a new interval. A hit before the first start in time mode stores nothing.
- R6: The count saturates at 32767 and does not wrap. A pulse that arrives while the count is already 32767 sets the overrange bit of that result. A count of exactly 32767 keeps the overrange bit at 0.
- R7: Up to four results wait in the buffer, and they leave in the order they were captured.
- R8: A result captured while four results are waiting and none is leaving in that cycle is discarded. It sets `overflow`, which stays high until reset.
- R9: Each result is sent as a 16-bit frame: the overrange bit first, then count bits 14 down to 0. `ser_valid` is high on each of the 16 bits, and `ser_frame` is high only on the first. Waiting results follow with no idle cycle between frames.
- R10: `hit` has no effect in signal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_time | input | 1 | 0: signal (event count) mode, 1: time (timestamp) mode; static |
| start | input | 1 | Synchronous start: clear counter, begin window or interval |
| win_len | input | 16 | Counting window length in clock cycles (signal mode) |
| evt_in | input | 1 | Single-cycle quantizer event pulse |
| ref_tick | input | 1 | Single-cycle reference tick |
| hit | input | 1 | Hit pulse to be timestamped (time mode) |
| ser_data | output | 1 | Serial result bit |
| ser_valid | output | 1 | High while `ser_data` carries a frame bit |
| ser_frame | output | 1 | High on the first bit of each frame |
| overflow | output | 1 | Sticky flag: a result was discarded because the buffer was full |

## Verification
Signal mode is driven with three event patterns: a sparse one pulse every third cycle, a dense burst that lasts past the window, and an empty window of length zero. Together they separate counting against the window edges from counting of stray inputs. Throughout signal mode the reference ticks and hits stay active, to show that the input multiplexer ignores them. Time mode is tried three ways: with hits at scattered offsets; with ticks on every other cycle, which separates a count of ticks from a count of cycles; and with a burst of consecutive hits, which fills the buffer and forces the overflow drop. A long interval crosses the saturation point, with one hit exactly at full scale and one past it.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

  typedef enum logic {
    MODE_SIGNAL = 1'b0,
    MODE_TIME   = 1'b1
  } ptd_mode_e;

  localparam int PTD_CNT_W = 15;
  localparam int PTD_DEPTH = 4;
  localparam int PTD_WIN_W = 16;

endpackage

// File: rtl/ptd_counter.sv
module ptd_counter
  import ptd_pkg::*;
#(
  parameter int CNT_W = PTD_CNT_W,
  parameter int WIN_W = PTD_WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ptd_mode_e        mode,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  input  logic             evt_in,
  input  logic             ref_tick,
  input  logic             hit,
  output logic             cap_valid,
  output logic [CNT_W:0]   cap_word
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // one step of the saturating accumulator: {overrange, count}
  function automatic logic [CNT_W:0] bump(input logic [CNT_W:0] w);
    if (w[CNT_W-1:0] == CNT_MAX) return {1'b1, CNT_MAX};
    return {w[CNT_W], w[CNT_W-1:0] + 1'b1};
  endfunction

  logic             tick_sel;
  logic             count_en;
  logic             running;
  logic             win_done;
  logic [WIN_W-1:0] rem;
  logic [CNT_W:0]   acc;

  // source multiplexer: exactly one pulse stream reaches the counter
  assign tick_sel = (mode == MODE_TIME) ? ref_tick : evt_in;
  assign count_en = running & tick_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      running  <= 1'b0;
      rem      <= '0;
      win_done <= 1'b0;
    end else begin
      win_done <= 1'b0;
      if (start) begin
        acc <= '0;
        if (mode == MODE_TIME) begin
          running <= 1'b1;
          rem     <= '0;
        end else begin
          running  <= (win_len != '0);
          rem      <= win_len;
          win_done <= (win_len == '0);
        end
      end else begin
        if (count_en) acc <= bump(acc);
        if (running && mode == MODE_SIGNAL) begin
          rem <= rem - WIN_W'(1);
          if (rem == WIN_W'(1)) begin
            running  <= 1'b0;
            win_done <= 1'b1;
          end
        end
      end
    end
  end

  assign cap_valid = (mode == MODE_TIME) ? (hit & running) : win_done;
  assign cap_word  = acc;

  p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc == '0));

  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc[CNT_W-1:0] == CNT_MAX && !start) |=> (acc[CNT_W-1:0] == CNT_MAX));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !count_en) |=> $stable(acc));

  p_ovr_at_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc[CNT_W]) |-> ($past(acc[CNT_W-1:0]) == CNT_MAX));

endmodule

// File: rtl/ptd_buffer.sv
module ptd_buffer #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty,
  output logic         overflow
);

  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [FW-1:0] fill;
  logic [FW-1:0] wr_idx;
  logic          full;
  logic          accept;
  logic          drop;

  assign full     = (fill == FW'(DEPTH));
  assign accept   = push & (~full | pop);
  assign drop     = push & full & ~pop;
  assign wr_idx   = fill - FW'(pop);
  assign head     = mem[0];
  assign nonempty = (fill != '0);

  // each entry either takes the new word or moves one place toward the head
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    if (gi < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (accept && wr_idx == FW'(gi)) mem[gi] <= push_word;
        else if (pop)                   mem[gi] <= mem[gi+1];
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (accept && wr_idx == FW'(gi)) mem[gi] <= push_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      fill     <= fill + FW'(accept) - FW'(pop);
      overflow <= overflow | drop;
    end
  end

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: rtl/ptd_serializer.sv
module ptd_serializer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nonempty,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         ser_data,
  output logic         ser_valid,
  output logic         ser_frame
);

  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [BW-1:0] left;
  logic          busy;
  logic          last;

  assign last = busy && (left == BW'(1));
  assign pop  = nonempty && (!busy || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (pop) begin
      sh   <= head;
      left <= BW'(W);
      busy <= 1'b1;
    end else if (busy) begin
      sh   <= sh << 1;
      left <= left - BW'(1);
      if (last) busy <= 1'b0;
    end
  end

  assign ser_valid = busy;
  assign ser_data  = busy & sh[W-1];
  assign ser_frame = busy && (left == BW'(W));

  p_frame_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |-> ser_valid);

  p_frame_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |=> !ser_frame);

  p_rise_is_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> ser_frame);

endmodule

// File: rtl/pulse_time_digitizer.sv
module pulse_time_digitizer
  import ptd_pkg::*;
#(
  parameter int CNT_W = PTD_CNT_W,
  parameter int DEPTH = PTD_DEPTH,
  parameter int WIN_W = PTD_WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_time,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  input  logic             evt_in,
  input  logic             ref_tick,
  input  logic             hit,
  output logic             ser_data,
  output logic             ser_valid,
  output logic             ser_frame,
  output logic             overflow
);

  localparam int WORD_W = CNT_W + 1;

  logic              cap_valid;
  logic [WORD_W-1:0] cap_word;
  logic [WORD_W-1:0] head;
  logic              nonempty;
  logic              pop;

  ptd_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (ptd_mode_e'(mode_time)),
    .start    (start),
    .win_len  (win_len),
    .evt_in   (evt_in),
    .ref_tick (ref_tick),
    .hit      (hit),
    .cap_valid(cap_valid),
    .cap_word (cap_word)
  );

  ptd_buffer #(.W(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cap_valid),
    .push_word(cap_word),
    .pop      (pop),
    .head     (head),
    .nonempty (nonempty),
    .overflow (overflow)
  );

  ptd_serializer #(.W(WORD_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .nonempty (nonempty),
    .head     (head),
    .pop      (pop),
    .ser_data (ser_data),
    .ser_valid(ser_valid),
    .ser_frame(ser_frame)
  );

endmodule

// File: tb/test_pulse_time_digitizer.sv
`timescale 1ns/1ps
module test_pulse_time_digitizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_time = 1'b0;
  logic        start = 1'b0;
  logic [15:0] win_len = '0;
  logic        evt_in = 1'b0;
  logic        ref_tick = 1'b0;
  logic        hit = 1'b0;
  logic        ser_data, ser_valid, ser_frame, overflow;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_time_digitizer i_pulse_time_digitizer (
    .clk(clk), .rst_n(rst_n), .mode_time(mode_time), .start(start),
    .win_len(win_len), .evt_in(evt_in), .ref_tick(ref_tick), .hit(hit),
    .ser_data(ser_data), .ser_valid(ser_valid), .ser_frame(ser_frame),
    .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int        m_cnt, m_rem, m_left;
  bit        m_ovr, m_run, m_done, m_ovf, m_busy;
  bit [15:0] m_sh;
  bit [15:0] m_q[$];

  always @(posedge clk) begin
    bit        cap, tick, nd;
    bit [15:0] cw;
    if (!rst_n) begin
      m_cnt = 0; m_rem = 0; m_left = 0; m_ovr = 0; m_run = 0; m_done = 0;
      m_ovf = 0; m_busy = 0; m_sh = 0; m_q.delete();
    end else begin
      cw  = {m_ovr, m_cnt[14:0]};
      cap = mode_time ? (hit && m_run) : m_done;
      if (m_q.size() > 0 && (!m_busy || m_left == 1)) begin
        m_sh = m_q.pop_front(); m_left = 16; m_busy = 1;
      end else if (m_busy) begin
        m_sh = m_sh << 1; m_left--;
        if (m_left == 0) m_busy = 0;
      end
      if (cap) begin
        if (m_q.size() < 4) m_q.push_back(cw);
        else m_ovf = 1;
      end
      tick = mode_time ? ref_tick : evt_in;
      nd = 0;
      if (start) begin
        m_cnt = 0; m_ovr = 0;
        if (mode_time) begin m_run = 1; m_rem = 0; end
        else begin m_run = (win_len != 0); m_rem = win_len; nd = (win_len == 0); end
      end else begin
        if (m_run && tick) begin
          if (m_cnt == 32767) m_ovr = 1; else m_cnt++;
        end
        if (m_run && !mode_time) begin
          m_rem--;
          if (m_rem == 0) begin m_run = 0; nd = 1; end
        end
      end
      m_done = nd;
    end
  end

  // every-cycle comparison against the model (R1, R8, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 valid", 32'(ser_valid), 32'(m_busy));
      chk("R9 frame", 32'(ser_frame), 32'(m_busy && m_left == 16));
      if (m_busy) chk("R9 data", 32'(ser_data), 32'(m_sh[15]));
      chk("R8 overflow", 32'(overflow), 32'(m_ovf));
    end
  end

  // frame assembler on the serial port
  logic [15:0] got[$];
  logic [15:0] asm_w;
  int          asm_n = 0;
  always @(negedge clk) begin
    if (rst_n && ser_valid) begin
      if (ser_frame) asm_n = 0;
      asm_w = {asm_w[14:0], ser_data};
      asm_n++;
      if (asm_n == 16) begin got.push_back(asm_w); asm_n = 0; end
    end
  end

  task automatic expect_words(input string req, input logic [15:0] exp[$]);
    chk({req, " count"}, 32'(got.size()), 32'(exp.size()));
    foreach (exp[i]) begin
      if (got.size() > 0) chk(req, 32'(got.pop_front()), 32'(exp[i]));
    end
    got.delete();
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic drain();
    repeat (120) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] e[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(ser_valid), 0);
    chk("R1 frame", 32'(ser_frame), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 no frames", 32'(got.size()), 0);

    // R3 R2 R10: sparse events, ticks and hits active but ignored
    mode_time = 1'b0; win_len = 16'd20;
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); start = 1'b0;
      evt_in = (i % 3 == 0); ref_tick = 1'b1; hit = 1'b1;
    end
    @(negedge clk); evt_in = 0; ref_tick = 0; hit = 0;
    drain();
    e = '{16'd7};
    expect_words("R3 sparse window", e);

    // R3: dense burst outlasting a 10-cycle window
    win_len = 16'd10;
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); start = 1'b0; evt_in = 1'b1;
    end
    @(negedge clk); evt_in = 0;
    drain();
    e = '{16'd10};
    expect_words("R3 burst window", e);

    // R3 boundary: zero-length window
    win_len = 16'd0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; evt_in = 1'b1;
    @(negedge clk); evt_in = 1'b0;
    drain();
    e = '{16'd0};
    expect_words("R3 empty window", e);

    // R5: hit before any start in time mode stores nothing
    mode_time = 1'b1;
    @(negedge clk); hit = 1'b1;
    @(negedge clk); hit = 1'b0;
    drain();
    e = {};
    expect_words("R5 hit before start", e);

    // R4 R2: ticks every cycle, events ignored, hits at 5, 12, 30
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); start = 1'b0;
      ref_tick = 1'b1; evt_in = 1'b1;
      hit = (k == 5 || k == 12 || k == 30);
    end
    @(negedge clk); ref_tick = 0; evt_in = 0; hit = 0;
    drain();
    e = '{16'd5, 16'd12, 16'd30};
    expect_words("R4 timestamps", e);

    // R4: ticks on even cycles only, hits at 7 and 20
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 22; k++) begin
      @(negedge clk); start = 1'b0;
      ref_tick = (k % 2 == 0); hit = (k == 7 || k == 20);
    end
    @(negedge clk); ref_tick = 0; hit = 0;
    drain();
    e = '{16'd4, 16'd10};
    expect_words("R4 sparse ticks", e);

    // R5: restart mid interval
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk); ref_tick = 1'b1;
      start = (k == 5); hit = (k == 8);
    end
    @(negedge clk); ref_tick = 0; hit = 0; start = 0;
    drain();
    e = '{16'd2};
    expect_words("R5 restart", e);

    // R7 R8: six back-to-back hits, one dropped
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); start = 1'b0;
      ref_tick = 1'b1; hit = (k >= 10);
    end
    @(negedge clk); ref_tick = 0; hit = 0;
    drain();
    e = '{16'd10, 16'd11, 16'd12, 16'd13, 16'd14};
    expect_words("R7 order", e);
    chk("R8 overflow set", 32'(overflow), 1);

    // R6: saturation boundary
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 32801; k++) begin
      @(negedge clk); start = 1'b0;
      ref_tick = 1'b1; hit = (k == 32767 || k == 32800);
    end
    @(negedge clk); ref_tick = 0; hit = 0;
    drain();
    e = '{16'h7FFF, 16'hFFFF};
    expect_words("R6 saturation", e);
    chk("R8 overflow sticky", 32'(overflow), 1);

    // R1 R8: reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 overflow after reset", 32'(overflow), 0);
    chk("R1 valid after reset", 32'(ser_valid), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule